// File: doc/BRIEF.md
# Cascade-Serial FIR Filter with Chained Accumulators

This block is a partly serial finite impulse response filter with constant coefficients. Its taps are split into partitions, and the length of each partition is a parameter. Each partition owns one multiply-accumulate unit. That unit works through the partition's taps, one per clock, over a sample period of L clocks, where L is the length of the longest partition. A partition shorter than L contributes nothing on its spare cycles.

There is no separate final adder. On the last cycle of a period, each partition adds the running total handed down from the partition after it and passes the result on toward partition 0. The accumulator of partition 0 therefore ends the period holding the complete output, and that register drives the result port directly.

Two partition lists mark the extremes. A single partition gives the fully serial filter, which takes one sample every TAPS clocks. Partitions of length one give the fully parallel filter, which takes one sample per clock.

Top module: `cascade_serial_fir`

## Requirements
- R1: When a sample is accepted, the output is y = sum over i of c[i]*x[i]. Here x[0] is the sample just accepted, x[i] is the sample accepted i samples earlier, and c[i] = ((7*i + 3) mod 17) - 8. Samples and coefficients are two's complement. The sum is exact in ACC_W bits.
- R2: Every partition list whose lengths add up to TAPS gives identical results. This includes one partition of length TAPS (fully serial) and TAPS partitions of length one (fully parallel). A list with any other sum is refused at elaboration.
- R3: in_valid is accepted when the filter is idle, or on the final cycle of a sample period. This allows back-to-back samples every L clocks. Each acceptance restarts the tap counter at zero.
- R4: A sample presented on a cycle of a period that is not the final cycle is dropped. It never enters the delay line, and it has no effect on later results.
- R5: out_valid rises exactly L clock edges after the edge that accepted the sample. It lasts one clock when L > 1. Each accepted sample produces exactly one output.
- R6: While the filter is idle, out_data holds the last result unchanged.
- R7: After reset, out_valid is 0, out_data is 0, and every delay-line element is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-clock strobe marking a finished result |
| out_data | output | ACC_W | Signed filter output, taken from partition 0's accumulator |

## Verification
The properties assume that in_valid is a plain level that is sampled on every edge, with no handshake back to the source. They also assume that a sample offered mid-period is meant to be lost, which is why the drop property only watches the newest delay-line element. The stimulus offers samples on exactly the edges where the filter should take them. It inserts deliberate extra strobes only in the mid-period cycles. A reference delay line in the bench is fed only with the samples that should be accepted, so any mid-period strobe that leaks into the design shows up as a wrong output value.

// File: rtl/cs_fir_pkg.sv
package cs_fir_pkg;

  localparam int LEN_FIELD_W = 8;
  localparam int MAX_PARTS   = 32;
  localparam int LIST_W      = LEN_FIELD_W * MAX_PARTS;

  function automatic int part_len(input logic [LIST_W-1:0] lens, input int p);
    return int'(lens[p*LEN_FIELD_W +: LEN_FIELD_W]);
  endfunction

  function automatic int part_base(input logic [LIST_W-1:0] lens, input int p);
    int acc;
    acc = 0;
    for (int q = 0; q < p; q++) acc += part_len(lens, q);
    return acc;
  endfunction

  function automatic int part_total(input logic [LIST_W-1:0] lens, input int n);
    return part_base(lens, n);
  endfunction

  function automatic int part_longest(input logic [LIST_W-1:0] lens, input int n);
    int m;
    m = 0;
    for (int q = 0; q < n; q++)
      if (part_len(lens, q) > m) m = part_len(lens, q);
    return m;
  endfunction

  function automatic int part_min(input logic [LIST_W-1:0] lens, input int n);
    int m;
    m = part_len(lens, 0);
    for (int q = 1; q < n; q++)
      if (part_len(lens, q) < m) m = part_len(lens, q);
    return m;
  endfunction

  function automatic int tap_coef(input int i);
    return ((7 * i + 3) % 17) - 8;
  endfunction

endpackage

// File: rtl/cs_tap_line.sv
module cs_tap_line #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic [DATA_W-1:0]        din,
  output logic [TAPS*DATA_W-1:0]   taps_o
);

  logic [TAPS*DATA_W-1:0] line_q, line_d;

  always_comb begin
    line_d = line_q;
    if (shift_en) begin
      line_d[DATA_W-1:0] = din;
      for (int i = 1; i < TAPS; i++)
        line_d[i*DATA_W +: DATA_W] = line_q[(i-1)*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign taps_o = line_q;

endmodule

// File: rtl/cs_tap_sequencer.sv
module cs_tap_sequencer #(
  parameter int SPAN  = 3,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [CNT_W-1:0] tap_o
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] tap_q, tap_d;
  logic             last_w, accept_w;

  assign last_w   = busy_q && (tap_q == CNT_W'(SPAN - 1));
  assign accept_w = in_valid && (!busy_q || last_w);

  always_comb begin
    busy_d = busy_q;
    tap_d  = tap_q;
    if (accept_w) begin
      busy_d = 1'b1;
      tap_d  = '0;
    end else if (last_w) begin
      busy_d = 1'b0;
      tap_d  = '0;
    end else if (busy_q) begin
      tap_d  = tap_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      tap_q  <= tap_d;
    end
  end

  assign accept_o = accept_w;
  assign busy_o   = busy_q;
  assign last_o   = last_w;
  assign tap_o    = tap_q;

endmodule

// File: rtl/cs_part_mac.sv
module cs_part_mac
  import cs_fir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 19,
  parameter int LEN    = 3,
  parameter int BASE   = 0,
  parameter int CNT_W  = 2,
  parameter bit HEAD   = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  input  logic                    last_i,
  input  logic [CNT_W-1:0]        tap_i,
  input  logic [LEN*DATA_W-1:0]   x_i,
  input  logic signed [ACC_W-1:0] chain_i,
  output logic signed [ACC_W-1:0] chain_o
);

  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [DATA_W-1:0] x_sel;
  logic signed [COEF_W-1:0] c_sel;
  logic                     hit;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  partial, handed, acc_q, acc_d;

  always_comb begin
    x_sel = '0;
    c_sel = '0;
    hit   = 1'b0;
    for (int j = 0; j < LEN; j++) begin
      if (tap_i == CNT_W'(j)) begin
        x_sel = x_i[j*DATA_W +: DATA_W];
        c_sel = COEF_W'(tap_coef(BASE + j));
        hit   = 1'b1;
      end
    end
  end

  assign prod    = hit ? PROD_W'(x_sel * c_sel) : '0;
  assign partial = ((tap_i == '0) ? '0 : acc_q) + ACC_W'(prod);
  assign handed  = partial + chain_i;

  always_comb begin
    acc_d = acc_q;
    if (run_i) acc_d = last_i ? handed : partial;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  generate
    if (HEAD) begin : g_head
      assign chain_o = acc_q;
    end else begin : g_link
      assign chain_o = handed;
    end
  endgenerate

endmodule

// File: rtl/cascade_serial_fir.sv
module cascade_serial_fir
  import cs_fir_pkg::*;
#(
  parameter int               DATA_W = 8,
  parameter int               COEF_W = 8,
  parameter int               TAPS   = 6,
  parameter int               NPART  = 3,
  parameter logic [LIST_W-1:0] PLENS = 256'h01_02_03,
  parameter int               ACC_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     out_valid,
  output logic signed [ACC_W-1:0]  out_data
);

  localparam int SPAN  = part_longest(PLENS, NPART);
  localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1;

  if (part_total(PLENS, NPART) != TAPS) begin : g_len_sum_err
    $error("partition lengths do not add up to TAPS");
  end
  if (part_min(PLENS, NPART) < 1) begin : g_len_zero_err
    $error("every partition needs at least one tap");
  end

  logic                    accept, busy, last;
  logic [CNT_W-1:0]        tap;
  logic [TAPS*DATA_W-1:0]  taps;
  logic signed [ACC_W-1:0] chain [NPART+1];
  logic                    valid_q, valid_d;

  cs_tap_sequencer #(.SPAN(SPAN), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .accept_o (accept),
    .busy_o   (busy),
    .last_o   (last),
    .tap_o    (tap)
  );

  cs_tap_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (in_data),
    .taps_o   (taps)
  );

  assign chain[NPART] = '0;

  for (genvar p = 0; p < NPART; p++) begin : g_part
    localparam int LEN  = part_len(PLENS, p);
    localparam int BASE = part_base(PLENS, p);
    cs_part_mac #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W),
      .LEN    (LEN),
      .BASE   (BASE),
      .CNT_W  (CNT_W),
      .HEAD   (p == 0)
    ) u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (busy),
      .last_i  (last),
      .tap_i   (tap),
      .x_i     (taps[BASE*DATA_W +: LEN*DATA_W]),
      .chain_i (chain[p+1]),
      .chain_o (chain[p])
    );
  end

  always_comb valid_d = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign out_valid = valid_q;
  assign out_data  = chain[0];

endmodule

// File: rtl/cs_fir_checker.sv
module cs_fir_checker #(
  parameter int SPAN   = 3,
  parameter int CNT_W  = 2,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              accept,
  input logic              busy,
  input logic              last,
  input logic [CNT_W-1:0]  tap,
  input logic [DATA_W-1:0] head,
  input logic              out_valid,
  input logic [ACC_W-1:0]  out_data
);

  // R3
  restart_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && tap == '0));

  // R3
  tap_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && tap == $past(tap) + CNT_W'(1)));

  // R3
  tap_in_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(tap) < SPAN));

  // R4
  drop_midperiod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy && !last) |=> $stable(head));

  // R5
  valid_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> out_valid);

  // R5
  valid_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(busy && last)) |=> !out_valid);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SPAN > 1 && out_valid) |=> !out_valid);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(out_data));

endmodule

bind cascade_serial_fir cs_fir_checker #(
  .SPAN(SPAN), .CNT_W(CNT_W), .DATA_W(DATA_W), .ACC_W(ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .accept    (accept),
  .busy      (busy),
  .last      (last),
  .tap       (tap),
  .head      (taps[DATA_W-1:0]),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/cascade_serial_fir_test.sv
module cascade_serial_fir_test;

  localparam int DW   = 8;
  localparam int TAPS = 6;
  localparam int AW   = 19;
  localparam int LM   = 3;
  localparam int LS   = 6;
  localparam int LP   = 1;

  logic clk, rst_n;
  logic iv_m, iv_s;
  logic [DW-1:0] d_m, d_s;
  logic ov_m, ov_s, ov_p;
  logic signed [AW-1:0] y_m, y_s, y_p;

  int total, bad, cyc;
  int hm [TAPS];
  int hs [TAPS];
  int qv_m[$], qc_m[$], qv_s[$], qc_s[$], qv_p[$], qc_p[$];
  int last_m;

  cascade_serial_fir uut (
    .clk(clk), .rst_n(rst_n), .in_valid(iv_m), .in_data(d_m),
    .out_valid(ov_m), .out_data(y_m));

  cascade_serial_fir #(.NPART(1), .PLENS(256'h06)) uut_ser (
    .clk(clk), .rst_n(rst_n), .in_valid(iv_s), .in_data(d_s),
    .out_valid(ov_s), .out_data(y_s));

  cascade_serial_fir #(.NPART(6), .PLENS(256'h01_01_01_01_01_01)) uut_par (
    .clk(clk), .rst_n(rst_n), .in_valid(iv_s), .in_data(d_s),
    .out_valid(ov_p), .out_data(y_p));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int cf(input int i);
    return ((7 * i + 3) % 17) - 8;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_m(input int v, input int acc);
    int y;
    for (int i = TAPS - 1; i > 0; i--) hm[i] = hm[i-1];
    hm[0] = v;
    y = 0;
    for (int i = 0; i < TAPS; i++) y += cf(i) * hm[i];
    qv_m.push_back(y);
    qc_m.push_back(acc + LM);
    last_m = y;
  endtask

  task automatic push_s(input int v, input int acc);
    int y;
    for (int i = TAPS - 1; i > 0; i--) hs[i] = hs[i-1];
    hs[0] = v;
    y = 0;
    for (int i = 0; i < TAPS; i++) y += cf(i) * hs[i];
    qv_s.push_back(y); qc_s.push_back(acc + LS);
    qv_p.push_back(y); qc_p.push_back(acc + LP);
  endtask

  // R1 R2 R5: every output is compared with the reference value and arrival edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (ov_m) begin
        if (qv_m.size() == 0) check(1'b0, "R5 extra output (main)", 1, 0);
        else begin
          check(int'(y_m) == qv_m[0], "R1 value (main)", int'(y_m), qv_m[0]);
          check(cyc == qc_m[0], "R5 latency (main)", cyc, qc_m[0]);
          void'(qv_m.pop_front()); void'(qc_m.pop_front());
        end
      end
      if (ov_s) begin
        if (qv_s.size() == 0) check(1'b0, "R5 extra output (serial)", 1, 0);
        else begin
          check(int'(y_s) == qv_s[0], "R2 value (serial)", int'(y_s), qv_s[0]);
          check(cyc == qc_s[0], "R5 latency (serial)", cyc, qc_s[0]);
          void'(qv_s.pop_front()); void'(qc_s.pop_front());
        end
      end
      if (ov_p) begin
        if (qv_p.size() == 0) check(1'b0, "R5 extra output (parallel)", 1, 0);
        else begin
          check(int'(y_p) == qv_p[0], "R2 value (parallel)", int'(y_p), qv_p[0]);
          check(cyc == qc_p[0], "R5 latency (parallel)", cyc, qc_p[0]);
          void'(qv_p.pop_front()); void'(qc_p.pop_front());
        end
      end
    end
  end

  // shared stream, one sample every 7 clocks, then an R6 hold check
  task automatic send_all(input int v);
    int acc;
    @(negedge clk);
    d_m = DW'(v); d_s = DW'(v); iv_m = 1'b1; iv_s = 1'b1;
    acc = cyc + 1;
    push_m(v, acc);
    push_s(v, acc);
    @(negedge clk);
    iv_m = 1'b0; iv_s = 1'b0;
    repeat (5) @(negedge clk);
    check(int'(y_m) == last_m, "R6 idle hold", int'(y_m), last_m);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 150000);
    summary();
  end

  initial begin
    total = 0; bad = 0; cyc = 0; last_m = 0;
    for (int i = 0; i < TAPS; i++) begin hm[i] = 0; hs[i] = 0; end
    rst_n = 1'b0; iv_m = 1'b0; iv_s = 1'b0; d_m = '0; d_s = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7
    check(ov_m == 1'b0, "R7 out_valid after reset", int'(ov_m), 0);
    check(int'(y_m) == 0, "R7 out_data after reset", int'(y_m), 0);
    check(int'(y_s) == 0, "R7 serial out_data after reset", int'(y_s), 0);

    // R1 R7: impulse response reads back the coefficients over zero history
    send_all(1);
    for (int i = 0; i < TAPS; i++) send_all(0);
    // R1: extreme values
    for (int i = 0; i < 7; i++) send_all(-128);
    for (int i = 0; i < 7; i++) send_all(127);
    // R1 R2: exhaustive sweep of the sample range
    for (int v = -128; v < 128; v++) send_all(v);

    // R3 R4: main instance back to back, mid-period strobes carry junk
    for (int i = 0; i < 64; i++) begin
      int acc;
      @(negedge clk);
      iv_m = 1'b1;
      d_m = DW'((i * 37 + 5) % 256);
      acc = cyc + 1;
      push_m(int'($signed(d_m)), acc);
      repeat (LM - 1) begin
        @(negedge clk);
        iv_m = i[0];
        d_m = 8'h7f - DW'(i);
      end
    end
    @(negedge clk);
    iv_m = 1'b0;
    repeat (12) @(negedge clk);
    // R5: every accepted sample produced its output
    check(qv_m.size() == 0, "R5 main outputs missing", qv_m.size(), 0);
    check(qv_s.size() == 0, "R5 serial outputs missing", qv_s.size(), 0);
    check(qv_p.size() == 0, "R5 parallel outputs missing", qv_p.size(), 0);
    summary();
  end

endmodule